// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the driver-enable of an RS-485 transceiver for a UART that runs half-duplex. It watches two transmit activity signals, the shift register busy flag and the holding FIFO non-empty flag, together with the UART's oversampling tick. It raises a direction signal on the clock edge after transmit data is first pending, with no lead time before the start bit. Once both activity signals have dropped, it holds that signal for a programmable number of whole bit periods before releasing the bus.

A 32-bit configuration word selects the behaviour. It chooses whether automatic control is on, which pin carries the direction (the RTS pin or a dedicated enable pin), the active level, and the hold time. A word written while the controller is driving the bus is staged. It takes effect only once the controller is idle, so a frame never sees its settings change part-way through.

Top module: `rs485_autodir`

## Requirements
- R1: With configuration bit 0 clear, `rtsPin` follows `modemRts` unchanged and `dePin` stays 0 whatever the transmit activity.
- R2: With bit 0 set, the direction becomes active on the first clock edge at which `txBusy` or `fifoNotEmpty` is sampled high, and it stays active while either one is high.
- R3: Bit 1 set routes the direction to `rtsPin` and holds `dePin` at 0. Bit 1 clear routes it to `dePin`, and `rtsPin` then follows `modemRts`.
- R4: Bit 2 clear drives the selected pin high while active and low otherwise. Bit 2 set inverts the selected pin, so it rests high and goes low while active.
- R5: Bits 11:8 give a hold count N (0 to 15). A bit period is 16 `sampleTick` pulses, or 8 when `sel8x` is 1. With a tick every cycle and activity high for P edges, the direction stays active for exactly P + N·period cycles. N = 0 releases on the edge where activity is first seen low.
- R6: Activity returning during the hold cancels the hold. The direction stays active without a gap, and a fresh full hold starts after the new activity ends.
- R7: A configuration word written with `cfgWe` while the direction is active, or while activity is pending, does not change the current frame's behaviour. It applies once the controller is idle.
- R8: After reset the active configuration is all zero, so `rtsPin` follows `modemRts` and `dePin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 32 | Configuration word (bit 0 enable, bit 1 pin select, bit 2 invert, bits 11:8 hold count) |
| txBusy | input | 1 | Transmit shift register busy |
| fifoNotEmpty | input | 1 | Transmit holding FIFO holds data |
| sampleTick | input | 1 | Oversampling tick from the baud generator |
| sel8x | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| modemRts | input | 1 | Software modem-control RTS level |
| rtsPin | output | 1 | RTS pin level |
| dePin | output | 1 | Dedicated driver-enable pin level |

## Verification
The pulse width on the selected pin is measured for hold counts 0, 1 and 15 on both pins and under both polarities. This separates an off-by-one in the hold counter from a wrong oversampling ratio, which the 8x runs expose. Frames that follow one another with a gap shorter than the hold must merge into one pulse. With a zero hold the same gap must give two pulses, which tells cancellation apart from release. A configuration write in the middle of a frame must leave that frame's width at the old hold and change only the next frame's. With automatic control off, activity must leave both pins untouched.

// File: rtl/rs485_autodir_pkg.sv
package rs485_autodir_pkg;
  localparam int CFG_W    = 32;
  localparam int EN_BIT   = 0;
  localparam int PIN_BIT  = 1;
  localparam int INV_BIT  = 2;
  localparam int HOLD_LSB = 8;
  localparam int HOLD_W   = 4;

  typedef struct packed {
    logic              en;
    logic              onRts;
    logic              invert;
    logic [HOLD_W-1:0] holdBits;
  } dirCfg_t;

  typedef struct packed {
    logic loadHold;
    logic cancelHold;
  } holdCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_HOLD} dirState_t;

  function automatic dirCfg_t decodeCfg(input logic [CFG_W-1:0] w);
    dirCfg_t c;
    c.en       = w[EN_BIT];
    c.onRts    = w[PIN_BIT];
    c.invert   = w[INV_BIT];
    c.holdBits = w[HOLD_LSB +: HOLD_W];
    return c;
  endfunction
endpackage

// File: rtl/rs485_autodir_ctrl.sv
module rs485_autodir_ctrl
  import rs485_autodir_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             txBusy,
  input  logic             fifoNotEmpty,
  input  logic             holdDone,
  output holdCmd_t         cmd,
  output dirCfg_t          cfgAct,
  output logic             dirOn
);
  dirState_t state, stateNext;
  dirCfg_t   cfgStaged;
  logic      stagedValid;
  logic      pending;
  logic      idleNow;

  assign pending = txBusy | fifoNotEmpty;
  assign idleNow = (state == ST_IDLE) && !pending;
  assign dirOn   = (state != ST_IDLE);

  always_comb begin
    stateNext      = state;
    cmd.loadHold   = 1'b0;
    cmd.cancelHold = 1'b0;
    unique case (state)
      ST_IDLE: if (pending) stateNext = ST_SEND;
      ST_SEND: if (!pending) begin
        if (cfgAct.holdBits == '0) stateNext = ST_IDLE;
        else begin
          stateNext    = ST_HOLD;
          cmd.loadHold = 1'b1;
        end
      end
      ST_HOLD: if (pending) begin
        stateNext      = ST_SEND;
        cmd.cancelHold = 1'b1;
      end else if (holdDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cfgAct      <= '0;
      cfgStaged   <= '0;
      stagedValid <= 1'b0;
    end else begin
      state <= stateNext;
      if (cfgWe) begin
        cfgStaged   <= decodeCfg(cfgData);
        stagedValid <= 1'b1;
      end
      if (idleNow) begin
        if (cfgWe) begin
          cfgAct      <= decodeCfg(cfgData);
          stagedValid <= 1'b0;
        end else if (stagedValid) begin
          cfgAct      <= cfgStaged;
          stagedValid <= 1'b0;
        end
      end
    end
  end

  a_r2_assert_on_pending: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> dirOn);
  a_r5_zero_hold_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !pending && cfgAct.holdBits == '0) |=> !dirOn);
  a_r6_cancel_to_send: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && pending) |=> (state == ST_SEND));
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (dirOn || pending) |=> $stable(cfgAct));
endmodule

// File: rtl/rs485_autodir_hold.sv
module rs485_autodir_hold
  import rs485_autodir_pkg::*;
#(
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  holdCmd_t          cmd,
  input  logic [HOLD_W-1:0] holdBits,
  input  logic              sampleTick,
  input  logic              sel8x,
  output logic              holdDone
);
  localparam int TW = $clog2(OVS_HI);
  localparam logic [TW-1:0] LAST_HI = TW'(OVS_HI - 1);
  localparam logic [TW-1:0] LAST_LO = TW'(OVS_LO - 1);

  logic [HOLD_W-1:0] remBits;
  logic [TW-1:0]     tickCnt;
  logic              running;
  logic              lastTick;

  assign lastTick = sampleTick && (tickCnt == (sel8x ? LAST_LO : LAST_HI));
  assign holdDone = running && lastTick && (remBits == HOLD_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remBits <= '0;
      tickCnt <= '0;
      running <= 1'b0;
    end else if (cmd.cancelHold) begin
      running <= 1'b0;
      tickCnt <= '0;
      remBits <= '0;
    end else if (cmd.loadHold) begin
      running <= (holdBits != '0);
      remBits <= holdBits;
      tickCnt <= '0;
    end else if (running && sampleTick) begin
      if (lastTick) begin
        tickCnt <= '0;
        remBits <= remBits - 1'b1;
        if (remBits == HOLD_W'(1)) running <= 1'b0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  a_r5_rem_live: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (remBits != '0));
  a_r6_cancel_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cancelHold |=> !running);
endmodule

// File: rtl/rs485_autodir.sv
module rs485_autodir
  import rs485_autodir_pkg::*;
#(
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgData,
  input  logic        txBusy,
  input  logic        fifoNotEmpty,
  input  logic        sampleTick,
  input  logic        sel8x,
  input  logic        modemRts,
  output logic        rtsPin,
  output logic        dePin
);
  holdCmd_t cmd;
  dirCfg_t  cfgAct;
  logic     dirOn;
  logic     holdDone;
  logic     lvl;

  rs485_autodir_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .txBusy(txBusy), .fifoNotEmpty(fifoNotEmpty), .holdDone(holdDone),
    .cmd(cmd), .cfgAct(cfgAct), .dirOn(dirOn)
  );

  rs485_autodir_hold #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_hold (
    .clk(clk), .rstN(rstN), .cmd(cmd), .holdBits(cfgAct.holdBits),
    .sampleTick(sampleTick), .sel8x(sel8x), .holdDone(holdDone)
  );

  assign lvl    = dirOn ^ cfgAct.invert;
  assign rtsPin = (cfgAct.en && cfgAct.onRts) ? lvl : modemRts;
  assign dePin  = (cfgAct.en && !cfgAct.onRts) ? lvl : 1'b0;
endmodule

// File: tb/rs485_autodir_tb.sv
module rs485_autodir_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, cfgWe = 0, txBusy = 0, fifoNotEmpty = 0;
  logic sampleTick = 1, sel8x = 0, modemRts = 1;
  logic [31:0] cfgData = '0;
  logic rtsPin, dePin;

  int checks = 0, fails = 0;
  int expQ[$];
  logic monOn = 0, monRts = 0, monInv = 0;
  int runLen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_autodir u_dut (.*);

  function automatic logic [31:0] mkCfg(logic en, logic rts, logic inv, int hold);
    return {20'b0, 4'(hold), 5'b0, inv, rts, en};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures active pulses on the selected pin and compares with queue
  always @(negedge clk) begin
    if (!monOn) runLen = 0;
    else if (((monRts ? rtsPin : dePin) ^ monInv) == 1'b1) runLen++;
    else if (runLen > 0) begin
      if (expQ.size() == 0) chk("R5 unexpected pulse", runLen, 0);
      else chk("R5/R6 pulse width", runLen, expQ.pop_front());
      runLen = 0;
    end
  end

  task automatic setCfg(logic en, logic rts, logic inv, int hold);
    monOn = 0;
    @(negedge clk); cfgWe = 1; cfgData = mkCfg(en, rts, inv, hold);
    @(negedge clk); cfgWe = 0;
    repeat (3) @(negedge clk);
    monRts = rts; monInv = inv; monOn = en;
  endtask

  task automatic sendFrame(int p, int expW, logic useFifo);
    expQ.push_back(expW);
    @(negedge clk);
    if (useFifo) fifoNotEmpty = 1; else txBusy = 1;
    repeat (p) @(negedge clk);
    txBusy = 0; fifoNotEmpty = 0;
    repeat (expW - p + 6) @(negedge clk);
  endtask

  task automatic runTests();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 rts follows modem", rtsPin, 1);
    chk("R8 de low", dePin, 0);
    // R1 disabled: activity has no effect
    modemRts = 0; txBusy = 1;
    repeat (4) @(negedge clk);
    chk("R1 rts follows modem", rtsPin, 0);
    chk("R1 de stays low", dePin, 0);
    txBusy = 0; modemRts = 1;
    repeat (4) @(negedge clk);
    // R2/R3 dedicated pin, active high, hold 0
    setCfg(1, 0, 0, 0);
    expQ.push_back(9);
    txBusy = 1;
    @(negedge clk);
    chk("R2 de active one edge after pending", dePin, 1);
    chk("R3 rts follows modem on de mode", rtsPin, 1);
    repeat (8) @(negedge clk);
    txBusy = 0;
    repeat (5) @(negedge clk);
    sendFrame(10, 26 - 16, 0);
    setCfg(1, 0, 0, 1);  sendFrame(10, 26, 0);
    setCfg(1, 0, 0, 15); sendFrame(10, 250, 0);
    // R4 inverted on RTS pin
    setCfg(1, 1, 1, 0);
    chk("R4 inverted idle high", rtsPin, 1);
    chk("R3 de held low in rts mode", dePin, 0);
    sendFrame(10, 10, 0);
    setCfg(1, 1, 1, 1);  sendFrame(10, 26, 0);
    setCfg(1, 1, 1, 15); sendFrame(10, 250, 1);
    // R4 inverted on dedicated pin
    setCfg(1, 0, 1, 1);
    chk("R4 inverted de idle high", dePin, 1);
    sendFrame(7, 23, 1);
    // R5 8x oversampling
    sel8x = 1;
    setCfg(1, 1, 0, 15); sendFrame(10, 130, 0);
    setCfg(1, 1, 0, 1);  sendFrame(10, 18, 1);
    sel8x = 0;
    // R6 back-to-back within hold: one merged pulse
    setCfg(1, 0, 0, 1);
    expQ.push_back(39);
    @(negedge clk); txBusy = 1;
    repeat (10) @(negedge clk); txBusy = 0;
    repeat (3) @(negedge clk);  fifoNotEmpty = 1;
    repeat (10) @(negedge clk); fifoNotEmpty = 0;
    repeat (30) @(negedge clk);
    // R6 zero hold, gap of one cycle: two pulses
    setCfg(1, 0, 0, 0);
    expQ.push_back(10); expQ.push_back(10);
    @(negedge clk); txBusy = 1;
    repeat (10) @(negedge clk); txBusy = 0;
    @(negedge clk); txBusy = 1;
    repeat (10) @(negedge clk); txBusy = 0;
    repeat (8) @(negedge clk);
    // R7 config write mid-frame deferred
    setCfg(1, 0, 0, 1);
    expQ.push_back(35);
    txBusy = 1;
    repeat (4) @(negedge clk);
    cfgWe = 1; cfgData = mkCfg(1, 0, 0, 3);
    @(negedge clk); cfgWe = 0;
    repeat (14) @(negedge clk); txBusy = 0;
    repeat (25) @(negedge clk);
    sendFrame(10, 58, 0); // R7 new hold applies on next frame
    // R1 again after disabling
    setCfg(0, 1, 0, 1);
    modemRts = 0; txBusy = 1;
    repeat (3) @(negedge clk);
    chk("R1 rts follows modem when off", rtsPin, 0);
    chk("R1 de low when off", dePin, 0);
    txBusy = 0;
    repeat (3) @(negedge clk);
    chk("R5 all pulses seen", expQ.size(), 0);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule